// File: doc/BRIEF.md
# Key-Protected GPIO Pad Controller

This block is a register-mapped general-purpose I/O controller for up to 32 pads. Software reaches it over a plain 32-bit register bus with single-cycle read and write strobes and byte offsets. A data-out register holds each pin's output value. Two per-pin mode bits, `mode_hi` and `mode_lo`, turn that value into a pad drive value and an output enable. The four pad behaviours are input, push-pull, open-drain (drive low only) and open-source (drive high only).

The mode registers are guarded. They accept writes only while a guard register is armed, and arming it takes a 16-bit magic key. Any other key value disarms it. Data-out and both mode registers have write-one-to-act set and clear aliases, so one pin can change without a read-modify-write. Pad levels are resynchronised by a two-flop chain before they are read back.

The `PIN_COUNT` parameter sets how many pins are live. Bits at or above it read as zero, ignore writes and never drive their pads.

Top module: `kgp_ctrl`

## Requirements
- R1: After a synchronous reset, the following are all zero: the guard status, both mode registers and data-out. Every pad has `pad_oe` low.
- R2: A write to offset 0x00 arms the guard when bits [15:0] equal 0xD42F and disarms it for any other value. Reading 0x00 returns the armed status in bit 31 and zeros in every other bit.
- R3: While the guard is disarmed, writes to offsets 0x08, 0x0C, 0x4C, 0x50, 0x54 and 0x58 leave both mode registers unchanged.
- R4: While the guard is armed, the mode registers update as follows. A write to 0x08 loads `mode_hi` and a write to 0x0C loads `mode_lo`. Each 1 in a write to 0x4C or 0x54 sets the matching bit of `mode_hi` or `mode_lo`. Each 1 in a write to 0x50 or 0x58 clears it. Zero bits leave the register alone.
- R5: Each 1 written to 0x14 sets the matching data-out bit and each 1 written to 0x18 clears it, whatever the guard state.
- R6: A pin with {mode_hi,mode_lo} = 00 keeps `pad_oe` low for either data-out value.
- R7: A pin with mode 01 has `pad_oe` high and drives its data-out value on `pad_out`.
- R8: A pin with mode 10 drives 0 when data-out is 0 and floats (`pad_oe` low) when data-out is 1.
- R9: A pin with mode 11 floats when data-out is 0 and drives 1 when data-out is 1.
- R10: A read of offset 0x04 returns `pad_in` after two register stages. A level applied between two rising edges first appears after the second of the following rising edges.
- R11: Bits at or above `PIN_COUNT` read as zero in every register, hold no written value, and never raise `pad_oe`.
- R12: Offsets 0x08 and 0x0C read back the mode registers. Every other offset, including the set and clear aliases, reads zero, and so does any cycle with `bus_rd` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is selected |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value driven on each pad |
| pad_oe | output | 32 | Per-pad output enable |

## Verification
The bench uses a six-pin configuration. It sweeps sixteen patterns in which mode codes and data values rotate across the pins, so every pin meets all four codes with both data values. Each pattern is split per mode code. A swapped enable or inverted value in one encoding therefore shows up against the other three. Guard tests write the same mode operations while armed, while disarmed, and after a near-miss key, which separates a real key compare from a partial one. Reads of full-width values and of pads above the sixth show that the pin-count mask holds on both the write path and the read path.

// File: rtl/kgp_pkg.sv
package kgp_pkg;
    localparam int MAX_PINS = 32;
    localparam int ADDR_W   = 8;
    localparam logic [15:0] GUARD_KEY = 16'hD42F;

    typedef enum logic [ADDR_W-1:0] {
        OFS_GUARD  = 8'h00,
        OFS_DIN    = 8'h04,
        OFS_MHI    = 8'h08,
        OFS_MLO    = 8'h0C,
        OFS_DSET   = 8'h14,
        OFS_DCLR   = 8'h18,
        OFS_MHISET = 8'h4C,
        OFS_MHICLR = 8'h50,
        OFS_MLOSET = 8'h54,
        OFS_MLOCLR = 8'h58
    } reg_ofs_e;

    typedef enum logic [1:0] {
        PAD_INPUT     = 2'b00,
        PAD_PUSHPULL  = 2'b01,
        PAD_OPEN_LOW  = 2'b10,
        PAD_OPEN_HIGH = 2'b11
    } pad_mode_e;

    typedef struct packed {
        logic oe;
        logic out;
    } pad_drv_t;

    function automatic pad_drv_t pad_encode(input pad_mode_e m, input logic d);
        pad_drv_t r;
        case (m)
            PAD_PUSHPULL:  begin r.oe = 1'b1; r.out = d;    end
            PAD_OPEN_LOW:  begin r.oe = ~d;   r.out = 1'b0; end
            PAD_OPEN_HIGH: begin r.oe = d;    r.out = 1'b1; end
            default:       begin r.oe = 1'b0; r.out = 1'b0; end
        endcase
        return r;
    endfunction

    function automatic logic [MAX_PINS-1:0] pin_mask(input int n);
        if (n >= MAX_PINS) return '1;
        return (MAX_PINS'(1) << n) - MAX_PINS'(1);
    endfunction
endpackage

// File: rtl/kgp_guard.sv
module kgp_guard
    import kgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_guard,
    input  logic [15:0] key,
    output logic        armed
);
    always_ff @(posedge clk) begin
        if (rst)           armed <= 1'b0;
        else if (wr_guard) armed <= (key == GUARD_KEY);
    end

    // R2
    key_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_guard && key == 16'hD42F) |=> armed);
    // R2
    key_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_guard && key != 16'hD42F) |=> !armed);
    // R2
    guard_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_guard |=> $stable(armed));
endmodule

// File: rtl/kgp_bitreg.sv
module kgp_bitreg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         set,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] dm;
    assign dm = din & MASK;

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ld)  q <= dm;
        else if (set) q <= q | dm;
        else if (clr) q <= q & ~dm;
    end

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld || set || clr) |=> $stable(q));
    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (set && !ld) |=> ((q & $past(dm)) == $past(dm)));
    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !ld && !set) |=> ((q & $past(dm)) == '0));
    // R11
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (q & ~MASK) == '0);
endmodule

// File: rtl/kgp_sync.sv
module kgp_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // R10
    sync_lag_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |=> (q == $past(d, 2)));
endmodule

// File: rtl/kgp_pad.sv
module kgp_pad
    import kgp_pkg::*;
#(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic [W-1:0] mode_hi,
    input  logic [W-1:0] mode_lo,
    input  logic [W-1:0] dout,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        if (MASK[g]) begin : g_live
            pad_drv_t drv;
            assign drv        = pad_encode(pad_mode_e'({mode_hi[g], mode_lo[g]}), dout[g]);
            assign pad_out[g] = drv.out;
            assign pad_oe[g]  = drv.oe;
        end else begin : g_dead
            assign pad_out[g] = 1'b0;
            assign pad_oe[g]  = 1'b0;
        end
    end
endmodule

// File: rtl/kgp_ctrl.sv
module kgp_ctrl
    import kgp_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [MAX_PINS-1:0] pad_in,
    output logic [MAX_PINS-1:0] pad_out,
    output logic [MAX_PINS-1:0] pad_oe
);
    localparam logic [MAX_PINS-1:0] LIVE = pin_mask(PIN_COUNT);

    logic                armed;
    logic [MAX_PINS-1:0] mode_hi, mode_lo, dout, din_sync;
    logic                hit_guard, hit_mhi, hit_mlo, hit_mhiset, hit_mhiclr;
    logic                hit_mloset, hit_mloclr, hit_dset, hit_dclr;

    assign hit_guard  = bus_wr && (bus_addr == OFS_GUARD);
    assign hit_mhi    = bus_wr && (bus_addr == OFS_MHI)    && armed;
    assign hit_mlo    = bus_wr && (bus_addr == OFS_MLO)    && armed;
    assign hit_mhiset = bus_wr && (bus_addr == OFS_MHISET) && armed;
    assign hit_mhiclr = bus_wr && (bus_addr == OFS_MHICLR) && armed;
    assign hit_mloset = bus_wr && (bus_addr == OFS_MLOSET) && armed;
    assign hit_mloclr = bus_wr && (bus_addr == OFS_MLOCLR) && armed;
    assign hit_dset   = bus_wr && (bus_addr == OFS_DSET);
    assign hit_dclr   = bus_wr && (bus_addr == OFS_DCLR);

    kgp_guard u_guard (
        .clk(clk), .rst(rst), .wr_guard(hit_guard),
        .key(bus_wdata[15:0]), .armed(armed)
    );

    kgp_bitreg #(.W(MAX_PINS), .MASK(LIVE)) u_mode_hi (
        .clk(clk), .rst(rst), .ld(hit_mhi), .set(hit_mhiset),
        .clr(hit_mhiclr), .din(bus_wdata), .q(mode_hi)
    );

    kgp_bitreg #(.W(MAX_PINS), .MASK(LIVE)) u_mode_lo (
        .clk(clk), .rst(rst), .ld(hit_mlo), .set(hit_mloset),
        .clr(hit_mloclr), .din(bus_wdata), .q(mode_lo)
    );

    kgp_bitreg #(.W(MAX_PINS), .MASK(LIVE)) u_dout (
        .clk(clk), .rst(rst), .ld(1'b0), .set(hit_dset),
        .clr(hit_dclr), .din(bus_wdata), .q(dout)
    );

    kgp_sync #(.W(MAX_PINS)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(din_sync)
    );

    kgp_pad #(.W(MAX_PINS), .MASK(LIVE)) u_pad (
        .mode_hi(mode_hi), .mode_lo(mode_lo), .dout(dout),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_GUARD: bus_rdata = {armed, 31'b0};
                OFS_DIN:   bus_rdata = din_sync & LIVE;
                OFS_MHI:   bus_rdata = mode_hi;
                OFS_MLO:   bus_rdata = mode_lo;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R3
    mode_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |=> ($stable(mode_hi) && $stable(mode_lo)));
    // R6
    input_float_chk: assert property (@(posedge clk) disable iff (rst)
        (~mode_hi & ~mode_lo & pad_oe) == '0);
    // R8
    open_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_hi & ~mode_lo & pad_oe & pad_out) == '0);
    // R9
    open_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_hi & mode_lo & pad_oe & ~pad_out) == '0);
    // R11
    dead_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~LIVE) == '0);
endmodule

// File: tb/kgp_ctrl_bench.sv
module kgp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 6;
    localparam logic [31:0] LIVE = 32'h3F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kgp_ctrl #(.PIN_COUNT(NPIN)) u_kgp_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        string tag [4] = '{"R6", "R7", "R8", "R9"};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 guard", 8'h00, 32'h0);
        rd_chk("R1 mode_hi", 8'h08, 32'h0);
        rd_chk("R1 mode_lo", 8'h0C, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);

        // R3 disarmed writes ignored
        wr(8'h54, 32'h3F);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h4C, 32'h3F);
        rd_chk("R3 mode_lo", 8'h0C, 32'h0);
        rd_chk("R3 mode_hi", 8'h08, 32'h0);
        chk("R3 pad_oe", pad_oe, 32'h0);

        // R2 key handling
        wr(8'h00, 32'hFFFF_D42F);
        rd_chk("R2 armed", 8'h00, 32'h8000_0000);
        wr(8'h00, 32'h0000_D42E);
        rd_chk("R2 near key", 8'h00, 32'h0);
        wr(8'h0C, 32'h3F);
        rd_chk("R3 after near key", 8'h0C, 32'h0);
        wr(8'h00, 32'h0000_D42F);
        rd_chk("R2 rearmed", 8'h00, 32'h8000_0000);

        // R4 armed writes, R11 masking
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R11 mode_lo mask", 8'h0C, 32'h3F);
        wr(8'h58, 32'h0000_0005);
        rd_chk("R4 mode_lo clear", 8'h0C, 32'h3A);
        wr(8'h54, 32'h0000_0001);
        rd_chk("R4 mode_lo set", 8'h0C, 32'h3B);
        wr(8'h4C, 32'hFFFF_FF30);
        rd_chk("R4 mode_hi set", 8'h08, 32'h30);
        wr(8'h50, 32'h0000_0010);
        rd_chk("R4 mode_hi clear", 8'h08, 32'h20);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h3F);
        rd_chk("R4 mode_hi load", 8'h08, 32'h0);

        // R5 data set/clear, guard independent
        wr(8'h14, 32'hFFFF_FFFF);
        chk("R5 data set out", pad_out, 32'h3F);
        chk("R7 push-pull oe", pad_oe, 32'h3F);
        wr(8'h18, 32'h0000_000A);
        chk("R5 data clear", pad_out, 32'h35);
        wr(8'h00, 32'h0);
        rd_chk("R2 released", 8'h00, 32'h0);
        wr(8'h14, 32'h0000_000A);
        chk("R5 set while disarmed", pad_out, 32'h3F);
        wr(8'h58, 32'h3F);
        rd_chk("R3 clear disarmed", 8'h0C, 32'h3F);
        chk("R3 pads held", pad_oe, 32'h3F);

        // R6..R9 sweep of encodings
        wr(8'h00, 32'hD42F);
        for (int p = 0; p < 16; p++) begin
            logic [31:0] mh, ml, dv, eoe, eout;
            logic [31:0] sel [4];
            mh = '0; ml = '0; dv = '0; eoe = '0; eout = '0;
            for (int k = 0; k < 4; k++) sel[k] = '0;
            for (int i = 0; i < NPIN; i++) begin
                int m;
                logic d;
                m = (p + i) % 4;
                d = ((p >> 2) + i / 2) % 2 == 1;
                mh[i] = m[1]; ml[i] = m[0]; dv[i] = d;
                sel[m][i] = 1'b1;
                case (m)
                    1: begin eoe[i] = 1'b1; eout[i] = d;    end
                    2: begin eoe[i] = !d;   eout[i] = 1'b0; end
                    3: begin eoe[i] = d;    eout[i] = 1'b1; end
                    default: begin eoe[i] = 1'b0; eout[i] = 1'b0; end
                endcase
            end
            wr(8'h08, mh);
            wr(8'h0C, ml);
            wr(8'h18, 32'hFFFF_FFFF);
            wr(8'h14, dv);
            for (int k = 0; k < 4; k++) begin
                chk({tag[k], " oe"}, pad_oe & sel[k], eoe & sel[k]);
                chk({tag[k], " drive"}, pad_out & pad_oe & sel[k], eout & eoe & sel[k]);
            end
            chk("R11 dead pads", pad_oe & ~LIVE, 32'h0);
        end

        // R10 synchronizer lag, R11 read mask
        pad_in = 32'hFFFF_FF2A;
        @(negedge clk);
        rd_chk("R10 one edge", 8'h04, 32'h0);
        @(negedge clk);
        rd_chk("R10 two edges", 8'h04, 32'h2A);
        pad_in = 32'h0000_0015;
        @(negedge clk);
        rd_chk("R10 hold old", 8'h04, 32'h2A);
        @(negedge clk);
        rd_chk("R10 new value", 8'h04, 32'h15);

        // R12 unmapped and alias reads
        rd_chk("R12 alias", 8'h14, 32'h0);
        rd_chk("R12 unmapped", 8'h30, 32'h0);
        bus_addr = 8'h0C;
        #1;
        chk("R12 no strobe", bus_rdata, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule